// File: doc/BRIEF.md
# Bus-Master DMA Register File

This block is the software-facing register set of a two-channel disk bus-master DMA controller. It sits behind a 16-byte I/O window whose base address is decoded elsewhere; the block sees only the four low offset bits, a read strobe, a write strobe and byte lanes. Offset bit 3 chooses the channel, and offset bits 2:0 choose the command register (0), the status register (2) or the descriptor-table pointer (4).

Each channel holds a start bit, a direction bit, a status byte, a descriptor-table pointer and a current-descriptor register. When software sets the start bit on a stopped channel, the block marks the channel active and latches the pointer into the current-descriptor register. It also sends a one-cycle start pulse to a companion transfer engine, which resets its buffer pointers on that pulse. The engine reports back through three set-on-event strobes per channel: interrupt, done and error. These update the status byte, and they take priority over a clearing write that lands in the same cycle.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, every register of both channels reads zero, the current-descriptor outputs are zero and no start pulse is driven.
- R2: Offset bit 3 is the channel and offset bits 2:0 the register (0 command, 2 status, 4 pointer). Other register offsets read all ones on the enabled byte lanes. Disabled byte lanes read zero. Lane n is data bits 8n+7:8n.
- R3: A command read returns the start bit at bit 0 and the direction bit at bit 3, with all other bits zero. A command write with lane 0 enabled loads both bits from data bits 0 and 3.
- R4: Writing start=1 to a stopped channel sets status bit 0 (active). It also copies the pointer into the current-descriptor output and raises that channel's start pulse for exactly the one cycle after the write edge.
- R5: Writing start=1 to a running channel gives no pulse and leaves the current descriptor unchanged. Writing start=0 to a stopped channel changes no status bit.
- R6: Writing start=0 to a running channel clears status bit 0.
- R7: A status write with lane 0 enabled loads bits 6:5 from the data. It clears bit 2 and bit 1 wherever the data bit is 1 and keeps them otherwise. It leaves bit 0 unchanged. Bits 7, 4 and 3 always read zero.
- R8: A pointer write updates only the enabled byte lanes, and bits 1:0 always read zero.
- R9: The interrupt event sets status bit 2. The done event clears bit 0 and sets bit 2. The error event clears bit 0 and sets bits 2 and 1.
- R10: An event and a status write that clears the same bit in the same cycle leave the bit set.
- R11: The two channels are independent: accesses and events on one channel change nothing in the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe; rdData is valid while high |
| addr | input | ADDR_W | Offset inside the I/O window |
| byteEn | input | 4 | Byte lanes of the access |
| wrData | input | 32 | Write data, right-aligned |
| rdData | output | 32 | Read data, combinational from addr |
| evtIrq | input | NCH | Engine interrupt event, per channel |
| evtDone | input | NCH | Engine end-of-table event, per channel |
| evtErr | input | NCH | Engine error event, per channel |
| startPulse | output | NCH | One-cycle start command to the engine |
| dirRead | output | NCH | Direction bit per channel |
| curDesc | output | NCH*32 | Current-descriptor register per channel, channel 0 in the low word |

## Verification
Two functions can act on a status bit in the same cycle: an engine event that sets it and a software status write that clears it. The bench first sets bits 2 and 1 with an error event. It then drives an interrupt event and a status write with data bits 2 and 1 set on the same clock edge. The expected status afterwards is 0x04: bit 2 is held by the event and bit 1 is cleared by the write.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  // register selected by offset bits 2:0
  typedef enum logic [1:0] {SEL_CMD, SEL_STAT, SEL_PTR, SEL_NONE} rdSel_t;

  // per-channel write strobes from control to datapath
  typedef struct packed {
    logic             cmdWr;
    logic             statWr;
    logic [LANES-1:0] ptrLane;
  } chanStb_t;
endpackage

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int CH_W = ADDR_W - 3,
  localparam int NCH  = 1 << CH_W
) (
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LANES-1:0]           byteEn,
  output chanStb_t [NCH-1:0]         stb,
  output rdSel_t                     rdSel,
  output logic [CH_W-1:0]            rdChan
);
  logic [2:0]      regOff;
  logic [CH_W-1:0] chanIdx;

  assign regOff  = addr[2:0];
  assign chanIdx = addr[ADDR_W-1:3];
  assign rdChan  = chanIdx;

  always_comb begin
    case (regOff)
      3'd0:    rdSel = SEL_CMD;
      3'd2:    rdSel = SEL_STAT;
      3'd4:    rdSel = SEL_PTR;
      default: rdSel = SEL_NONE;
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_stb
    always_comb begin
      stb[c] = '0;
      if (wrEn && chanIdx == CH_W'(c)) begin
        stb[c].cmdWr   = (regOff == 3'd0) && byteEn[0];
        stb[c].statWr  = (regOff == 3'd2) && byteEn[0];
        stb[c].ptrLane = (regOff == 3'd4) ? byteEn : '0;
      end
    end
  end
endmodule

// File: rtl/bmdma_data.sv
module bmdma_data
  import bmdma_pkg::*;
#(
  parameter int CH_W = 1,
  localparam int NCH = 1 << CH_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  chanStb_t [NCH-1:0]      stb,
  input  logic [BUS_W-1:0]        wrData,
  input  logic [NCH-1:0]          evtIrq,
  input  logic [NCH-1:0]          evtDone,
  input  logic [NCH-1:0]          evtErr,
  input  logic                    rdEn,
  input  rdSel_t                  rdSel,
  input  logic [CH_W-1:0]         rdChan,
  input  logic [LANES-1:0]        byteEn,
  output logic [BUS_W-1:0]        rdData,
  output logic [NCH-1:0]          startPulse,
  output logic [NCH-1:0]          dirRead,
  output logic [NCH*BUS_W-1:0]    curDesc,
  output logic [NCH-1:0][7:0]     statArr
);
  logic [NCH-1:0]            startArr;
  logic [NCH-1:0][BUS_W-1:0] ptrArr;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic             startQ, dirQ, pulseQ;
    logic [7:0]       statQ, statNext;
    logic [BUS_W-1:0] ptrQ, curQ;
    logic             rise, fall;

    assign rise = stb[c].cmdWr &&  wrData[0] && !startQ;
    assign fall = stb[c].cmdWr && !wrData[0] &&  startQ;

    always_comb begin
      statNext = statQ;
      if (stb[c].statWr) begin
        statNext[6:5] = wrData[6:5];
        statNext[2:1] = statQ[2:1] & ~wrData[2:1];
      end
      if (rise)      statNext[0] = 1'b1;
      else if (fall) statNext[0] = 1'b0;
      // engine events win over software in the same cycle
      if (evtDone[c] || evtErr[c])              statNext[0] = 1'b0;
      if (evtIrq[c] || evtDone[c] || evtErr[c]) statNext[2] = 1'b1;
      if (evtErr[c])                            statNext[1] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        startQ <= 1'b0;
        dirQ   <= 1'b0;
        pulseQ <= 1'b0;
        statQ  <= '0;
        ptrQ   <= '0;
        curQ   <= '0;
      end else begin
        pulseQ <= rise;
        statQ  <= statNext;
        if (stb[c].cmdWr) begin
          startQ <= wrData[0];
          dirQ   <= wrData[3];
        end
        if (rise) curQ <= ptrQ;
        for (int b = 0; b < LANES; b++) begin
          if (stb[c].ptrLane[b])
            ptrQ[8*b +: 8] <= wrData[8*b +: 8] & ((b == 0) ? 8'hFC : 8'hFF);
        end
      end
    end

    assign startPulse[c]            = pulseQ;
    assign dirRead[c]               = dirQ;
    assign curDesc[c*BUS_W +: BUS_W] = curQ;
    assign statArr[c]               = statQ;
    assign startArr[c]              = startQ;
    assign ptrArr[c]                = ptrQ;
  end

  logic [BUS_W-1:0] rawData, laneMask;

  always_comb begin
    case (rdSel)
      SEL_CMD:  rawData = {{(BUS_W-4){1'b0}}, dirRead[rdChan], 2'b00, startArr[rdChan]};
      SEL_STAT: rawData = {{(BUS_W-8){1'b0}}, statArr[rdChan]};
      SEL_PTR:  rawData = ptrArr[rdChan];
      default:  rawData = '1;
    endcase
    for (int b = 0; b < LANES; b++) laneMask[8*b +: 8] = {8{byteEn[b]}};
    rdData = rdEn ? (rawData & laneMask) : '0;
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int CH_W = ADDR_W - 3,
  localparam int NCH  = 1 << CH_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [LANES-1:0]       byteEn,
  input  logic [BUS_W-1:0]       wrData,
  output logic [BUS_W-1:0]       rdData,
  input  logic [NCH-1:0]         evtIrq,
  input  logic [NCH-1:0]         evtDone,
  input  logic [NCH-1:0]         evtErr,
  output logic [NCH-1:0]         startPulse,
  output logic [NCH-1:0]         dirRead,
  output logic [NCH*BUS_W-1:0]   curDesc
);
  chanStb_t [NCH-1:0] stb;
  rdSel_t             rdSel;
  logic [CH_W-1:0]    rdChan;
  logic [NCH-1:0][7:0] statArr;

  bmdma_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .byteEn(byteEn),
    .stb(stb), .rdSel(rdSel), .rdChan(rdChan)
  );

  bmdma_data #(.CH_W(CH_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .evtIrq(evtIrq), .evtDone(evtDone), .evtErr(evtErr),
    .rdEn(rdEn), .rdSel(rdSel), .rdChan(rdChan), .byteEn(byteEn),
    .rdData(rdData), .startPulse(startPulse), .dirRead(dirRead),
    .curDesc(curDesc), .statArr(statArr)
  );
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk
  import bmdma_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int CH_W = ADDR_W - 3,
  localparam int NCH  = 1 << CH_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [LANES-1:0]     byteEn,
  input logic [BUS_W-1:0]     wrData,
  input logic [BUS_W-1:0]     rdData,
  input logic [NCH-1:0]       evtIrq,
  input logic [NCH-1:0]       evtDone,
  input logic [NCH-1:0]       evtErr,
  input logic [NCH-1:0]       startPulse,
  input logic [NCH-1:0][7:0]  statArr
);
  logic [BUS_W-1:0] onesMask;
  logic             undefOff;

  always_comb begin
    for (int b = 0; b < LANES; b++) onesMask[8*b +: 8] = {8{byteEn[b]}};
    undefOff = (addr[2:0] != 3'd0) && (addr[2:0] != 3'd2) && (addr[2:0] != 3'd4);
  end

  // R2: undefined offsets read all ones on enabled lanes
  a_r2_undef_ones: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && undefOff) |-> (rdData == onesMask));

  // R8: pointer reads never show the two low bits
  a_r8_ptr_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[2:0] == 3'd4) |-> (rdData[1:0] == 2'b00));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic statWrHere;
    assign statWrHere = wrEn && byteEn[0] && addr[2:0] == 3'd2 &&
                        addr[ADDR_W-1:3] == CH_W'(c);

    // R4: a start pulse comes with the active bit set
    a_r4_pulse_active: assert property (@(posedge clk) disable iff (!rstN)
      (startPulse[c] && !$past(evtDone[c] || evtErr[c])) |-> statArr[c][0]);

    // R5: a start pulse never lasts two cycles
    a_r5_pulse_once: assert property (@(posedge clk) disable iff (!rstN)
      startPulse[c] |=> !startPulse[c]);

    // R7: a status write alone does not move the active bit
    a_r7_active_kept: assert property (@(posedge clk) disable iff (!rstN)
      (statWrHere && !evtDone[c] && !evtErr[c]) |=> $stable(statArr[c][0]));

    // R9: interrupt event sets bit 2
    a_r9_irq_sets: assert property (@(posedge clk) disable iff (!rstN)
      evtIrq[c] |=> statArr[c][2]);

    // R9: error event sets bits 2:1 and clears active
    a_r9_err_sets: assert property (@(posedge clk) disable iff (!rstN)
      evtErr[c] |=> (statArr[c][2:1] == 2'b11 && !statArr[c][0]));

    // R10: event beats a clearing write in the same cycle
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rstN)
      (statWrHere && wrData[1] && evtErr[c]) |=> statArr[c][1]);
  end
endmodule

bind bmdma_regs bmdma_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .byteEn(byteEn), .wrData(wrData), .rdData(rdData), .evtIrq(evtIrq),
  .evtDone(evtDone), .evtErr(evtErr), .startPulse(startPulse),
  .statArr(statArr)
);

// File: tb/bmdma_regs_test.sv
module bmdma_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [3:0]  byteEn = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  evtIrq = '0, evtDone = '0, evtErr = '0;
  logic [1:0]  startPulse, dirRead;
  logic [63:0] curDesc;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bmdma_regs uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .byteEn(byteEn), .wrData(wrData), .rdData(rdData), .evtIrq(evtIrq),
    .evtDone(evtDone), .evtErr(evtErr), .startPulse(startPulse),
    .dirRead(dirRead), .curDesc(curDesc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; byteEn = be;
    @(negedge clk);
    wrEn = 1'b0; byteEn = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a; byteEn = be;
    #1 d = rdData;
    rdEn = 1'b0; byteEn = '0;
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a, input logic [3:0] be,
                       input logic [31:0] exp);
    logic [31:0] d;
    rd(a, be, d);
    check(tag, d, exp);
  endtask

  task automatic ev(input int kind, input int ch);
    @(negedge clk);
    if (kind == 0) evtIrq[ch] = 1'b1;
    else if (kind == 1) evtDone[ch] = 1'b1;
    else evtErr[ch] = 1'b1;
    @(negedge clk);
    evtIrq = '0; evtDone = '0; evtErr = '0;
  endtask

  task automatic t_reset;
    rdChk("R1 cmd0", 4'h0, 4'hF, 32'h0);
    rdChk("R1 stat0", 4'h2, 4'hF, 32'h0);
    rdChk("R1 ptr0", 4'h4, 4'hF, 32'h0);
    rdChk("R1 stat1", 4'hA, 4'hF, 32'h0);
    rdChk("R1 ptr1", 4'hC, 4'hF, 32'h0);
    check("R1 curDesc", curDesc[31:0] | curDesc[63:32], 32'h0);
    check("R1 pulse", {30'b0, startPulse}, 32'h0);
  endtask

  task automatic t_pointer;
    wr(4'h4, 32'h1234_5677, 4'hF);
    rdChk("R8 ptr low bits", 4'h4, 4'hF, 32'h1234_5674);
    wr(4'h4, 32'hAABB_CCDD, 4'b0010);
    rdChk("R8 ptr lane1", 4'h4, 4'hF, 32'h1234_CC74);
    rdChk("R11 ptr1 untouched", 4'hC, 4'hF, 32'h0);
  endtask

  task automatic t_start;
    wr(4'h0, 32'h09, 4'h1);
    check("R4 pulse", {30'b0, startPulse}, 32'h1);
    check("R4 curDesc", curDesc[31:0], 32'h1234_CC74);
    @(negedge clk);
    check("R4 pulse one cycle", {30'b0, startPulse}, 32'h0);
    rdChk("R3 cmd read", 4'h0, 4'hF, 32'h09);
    check("R3 dirRead", {30'b0, dirRead}, 32'h1);
    rdChk("R4 active", 4'h2, 4'hF, 32'h01);
  endtask

  task automatic t_repeat;
    wr(4'h0, 32'hFF, 4'h1);
    check("R5 no pulse", {30'b0, startPulse}, 32'h0);
    rdChk("R3 only two bits", 4'h0, 4'hF, 32'h09);
    wr(4'h4, 32'h100, 4'hF);
    wr(4'h0, 32'h01, 4'h1);
    check("R5 no pulse again", {30'b0, startPulse}, 32'h0);
    check("R5 curDesc kept", curDesc[31:0], 32'h1234_CC74);
    rdChk("R3 dir cleared", 4'h0, 4'hF, 32'h01);
  endtask

  task automatic t_stop;
    wr(4'h0, 32'h00, 4'h1);
    rdChk("R6 active cleared", 4'h2, 4'hF, 32'h00);
    wr(4'h0, 32'h00, 4'h1);
    rdChk("R5 stop while stopped", 4'h2, 4'hF, 32'h00);
  endtask

  task automatic t_events;
    ev(0, 0);
    rdChk("R9 irq", 4'h2, 4'hF, 32'h04);
    wr(4'h0, 32'h01, 4'h1);
    check("R4 restart pulse", {30'b0, startPulse}, 32'h1);
    check("R4 restart curDesc", curDesc[31:0], 32'h100);
    rdChk("R4 restart active", 4'h2, 4'hF, 32'h05);
    ev(1, 0);
    rdChk("R9 done", 4'h2, 4'hF, 32'h04);
    ev(2, 0);
    rdChk("R9 err", 4'h2, 4'hF, 32'h06);
  endtask

  task automatic t_status;
    wr(4'h2, 32'h62, 4'h1);
    rdChk("R7 rw and w1c", 4'h2, 4'hF, 32'h64);
    wr(4'h0, 32'h00, 4'h1);
    wr(4'h0, 32'h01, 4'h1);
    rdChk("R7 active back", 4'h2, 4'hF, 32'h65);
    wr(4'h2, 32'h04, 4'h1);
    rdChk("R7 active kept", 4'h2, 4'hF, 32'h01);
    wr(4'h0, 32'h00, 4'h1);
    wr(4'h2, 32'h99, 4'h1);
    rdChk("R7 bit0 not writable", 4'h2, 4'hF, 32'h00);
  endtask

  task automatic t_concurrent;
    ev(2, 0);
    rdChk("R10 setup", 4'h2, 4'hF, 32'h06);
    @(negedge clk);
    evtIrq[0] = 1'b1;
    wrEn = 1'b1; addr = 4'h2; wrData = 32'h06; byteEn = 4'h1;
    @(negedge clk);
    evtIrq = '0; wrEn = 1'b0; byteEn = '0;
    rdChk("R10 event wins", 4'h2, 4'hF, 32'h04);
  endtask

  task automatic t_decode;
    rdChk("R2 off1", 4'h1, 4'hF, 32'hFFFF_FFFF);
    rdChk("R2 off5", 4'h5, 4'hF, 32'hFFFF_FFFF);
    rdChk("R2 off7", 4'h7, 4'hF, 32'hFFFF_FFFF);
    rdChk("R2 off13 byte", 4'hD, 4'b0001, 32'h0000_00FF);
    rdChk("R2 ptr half", 4'h4, 4'b0011, 32'h0000_0100);
  endtask

  task automatic t_channel;
    wr(4'h8, 32'h01, 4'h1);
    check("R11 ch1 pulse", {30'b0, startPulse}, 32'h2);
    check("R11 ch1 curDesc", curDesc[63:32], 32'h0);
    rdChk("R11 ch1 active", 4'hA, 4'hF, 32'h01);
    rdChk("R11 ch0 unchanged", 4'h2, 4'hF, 32'h04);
    ev(0, 1);
    rdChk("R11 ch1 irq", 4'hA, 4'hF, 32'h05);
    rdChk("R11 ch0 still", 4'h2, 4'hF, 32'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_pointer();
    t_start();
    t_repeat();
    t_stop();
    t_events();
    t_status();
    t_concurrent();
    t_decode();
    t_channel();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule